// File: doc/BRIEF.md
# TDM Multichannel Serial Output Framer

This block puts a group of parallel sample words onto one serial data line as a time-division-multiplexed frame. A sample strobe captures the six 16-bit words, the per-channel power mask and the operating mode into shadow registers. On the next bit-clock enable the block raises a frame sync for one bit period. Six fixed slots of sixteen bits follow, one slot per channel, with channel 1 first.

A slot whose channel is powered down keeps its place in the frame. For that slot the data-enable output is low, so an external three-state driver leaves the line floating. In program mode the frame sync is still sent once per sample period, but no slot drives data. If a strobe arrives before the current frame has finished, the block reports an overrun and restarts with a fresh frame. At a 16.384 MHz master clock the sample period is typically 125 µs. The strobe spacing must be at least one sync bit plus all slot bits of bit ticks.

Top module: `tdm_framer`

## Requirements
- R1: On the first clock edge with `bit_en` high after a captured strobe, `fsync` goes high for exactly one bit period, and `sd_oe` is low while `fsync` is high.
- R2: After the sync bit, six slots of 16 bit ticks each follow. Slot k carries channel k+1, whose word is `smp_data[16k+15:16k]`. Each word is sent MSB first, one bit per tick.
- R3: When `pwr_mask[k]` is 0, `sd_oe` is low for all 16 ticks of slot k. The other slots keep their positions and contents.
- R4: In program mode (`mode` = 2'b00), `sd_oe` stays low for the whole frame, and `fsync` is still sent.
- R5: Data mode (2'b01) and mixed mode (2'b10) both transmit the powered-up slots. The code 2'b11 behaves as program mode.
- R6: `smp_data`, `pwr_mask` and `mode` are captured only on a clock edge where `smp_stb` is high. Later changes have no effect on the frame being sent.
- R7: A strobe that arrives while a frame is pending or in progress raises `overrun` for one clock, in the cycle after the strobe, and the next tick starts a new frame with `fsync`. A strobe that arrives while the block is idle leaves `overrun` low.
- R8: The tick after the last bit of slot 6 drives `sd_oe` low. With no further strobe, no `fsync` is produced.
- R9: During and after reset, `fsync`, `sd_oe`, `sd_out` and `overrun` are low until a strobe arrives.
- R10: `sd_out` is low whenever `sd_oe` is low.
- R11: `sd_out`, `sd_oe` and `fsync` change only on clock edges where `bit_en` or `smp_stb` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-clock enable, one serial bit per high cycle |
| smp_stb | input | 1 | Sample strobe; captures words, mask and mode |
| smp_data | input | 96 | Six sample words, channel 1 in bits 15:0 |
| pwr_mask | input | 6 | Per-channel power-up bits, bit 0 = channel 1 |
| mode | input | 2 | 00 program, 01 data, 10 mixed, 11 treated as program |
| sd_out | output | 1 | Serial data bit |
| sd_oe | output | 1 | Data enable for an external three-state driver |
| fsync | output | 1 | Frame sync pulse, one bit period long |
| overrun | output | 1 | One-clock pulse when a strobe interrupts a frame |

## Verification
The strobe edge captures the inputs. The overrun pulse is due in the clock right after that edge and is gone one clock later. The first tick after the strobe shows `fsync`. Bit b of the frame (0..95) appears after tick b+2 counted from the strobe, and the tail tick (the 98th) returns the line to quiet. The bench raises `bit_en` for exactly one clock per tick and samples on the falling edge after the tick's rising edge. It then samples once more, one falling edge later and with no enable, to confirm that the outputs hold between ticks.

// File: rtl/tdm_fr_pkg.sv
package tdm_fr_pkg;

   typedef enum logic [1:0] {
      MD_PROGRAM = 2'b00,
      MD_DATA    = 2'b01,
      MD_MIXED   = 2'b10,
      MD_RSVD    = 2'b11
   } tdm_mode_e;

   // True for the modes that put converter samples on the line
   function automatic logic mode_sends(input tdm_mode_e m);
      return (m == MD_DATA) || (m == MD_MIXED);
   endfunction

endpackage

// File: rtl/tdm_fr_capture.sv
module tdm_fr_capture
   import tdm_fr_pkg::*;
#(
   parameter int NCH = 6,
   parameter int W   = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 smp_stb,
   input  logic                 bit_en,
   input  logic [NCH*W-1:0]     smp_data,
   input  logic [NCH-1:0]       pwr_mask,
   input  logic [1:0]           mode_i,
   input  logic                 busy_i,
   output logic [NCH*W-1:0]     words_o,
   output logic [NCH-1:0]       mask_o,
   output tdm_mode_e            mode_o,
   output logic                 start_o,
   output logic                 overrun_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         words_o   <= '0;
         mask_o    <= '0;
         mode_o    <= MD_PROGRAM;
         start_o   <= 1'b0;
         overrun_o <= 1'b0;
      end else begin
         if (smp_stb) begin
            words_o <= smp_data;
            mask_o  <= pwr_mask;
            mode_o  <= tdm_mode_e'(mode_i);
         end
         // a pending start survives until a bit tick consumes it
         start_o   <= smp_stb | (start_o & ~bit_en);
         overrun_o <= smp_stb & (busy_i | start_o);
      end
   end

endmodule

// File: rtl/tdm_fr_sequencer.sv
module tdm_fr_sequencer #(
   parameter int NCH = 6,
   parameter int W   = 16,
   localparam int SW = $clog2(NCH),
   localparam int BW = $clog2(W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bit_en,
   input  logic          start_i,
   output logic          fsync_o,
   output logic          run_o,
   output logic [SW-1:0] slot_o,
   output logic [BW-1:0] bit_o
);

   localparam logic [SW-1:0] LAST_SLOT = SW'(NCH - 1);
   localparam logic [BW-1:0] LAST_BIT  = BW'(W - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fsync_o <= 1'b0;
         run_o   <= 1'b0;
         slot_o  <= '0;
         bit_o   <= '0;
      end else if (bit_en) begin
         if (start_i) begin
            fsync_o <= 1'b1;
            run_o   <= 1'b0;
            slot_o  <= '0;
            bit_o   <= '0;
         end else if (fsync_o) begin
            fsync_o <= 1'b0;
            run_o   <= 1'b1;
         end else if (run_o) begin
            if (bit_o == LAST_BIT) begin
               bit_o <= '0;
               if (slot_o == LAST_SLOT) begin
                  run_o  <= 1'b0;
                  slot_o <= '0;
               end else begin
                  slot_o <= slot_o + 1'b1;
               end
            end else begin
               bit_o <= bit_o + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/tdm_fr_bitsel.sv
module tdm_fr_bitsel
   import tdm_fr_pkg::*;
#(
   parameter int NCH       = 6,
   parameter int W         = 16,
   parameter bit MSB_FIRST = 1'b1,
   localparam int SW = $clog2(NCH),
   localparam int BW = $clog2(W)
) (
   input  logic [NCH*W-1:0] words_i,
   input  logic [NCH-1:0]   mask_i,
   input  tdm_mode_e        mode_i,
   input  logic             run_i,
   input  logic [SW-1:0]    slot_i,
   input  logic [BW-1:0]    bit_i,
   output logic             sd_o,
   output logic             oe_o
);

   logic [W-1:0]  word_sel;
   logic [BW-1:0] idx;

   generate
      if (MSB_FIRST) begin : g_msb
         assign idx = BW'(W - 1) - bit_i;
      end else begin : g_lsb
         assign idx = bit_i;
      end
   endgenerate

   always_comb begin
      word_sel = words_i[int'(slot_i)*W +: W];
      oe_o     = run_i & mode_sends(mode_i) & mask_i[slot_i];
      sd_o     = oe_o & word_sel[idx];
   end

endmodule

// File: rtl/tdm_framer.sv
module tdm_framer
   import tdm_fr_pkg::*;
#(
   parameter int NCH       = 6,
   parameter int W         = 16,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bit_en,
   input  logic               smp_stb,
   input  logic [NCH*W-1:0]   smp_data,
   input  logic [NCH-1:0]     pwr_mask,
   input  logic [1:0]         mode,
   output logic               sd_out,
   output logic               sd_oe,
   output logic               fsync,
   output logic               overrun
);

   localparam int SW = $clog2(NCH);
   localparam int BW = $clog2(W);

   generate
      if (NCH < 2) begin : g_bad_nch
         $error("tdm_framer: NCH must be at least 2");
      end
      if (W < 2) begin : g_bad_w
         $error("tdm_framer: W must be at least 2");
      end
   endgenerate

   logic [NCH*W-1:0] words_q;
   logic [NCH-1:0]   mask_q;
   tdm_mode_e        mode_q;
   logic             start_q;
   logic             run_q;
   logic [SW-1:0]    slot_q;
   logic [BW-1:0]    bit_q;

   tdm_fr_capture #(.NCH(NCH), .W(W)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_stb   (smp_stb),
      .bit_en    (bit_en),
      .smp_data  (smp_data),
      .pwr_mask  (pwr_mask),
      .mode_i    (mode),
      .busy_i    (fsync | run_q),
      .words_o   (words_q),
      .mask_o    (mask_q),
      .mode_o    (mode_q),
      .start_o   (start_q),
      .overrun_o (overrun)
   );

   tdm_fr_sequencer #(.NCH(NCH), .W(W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .bit_en  (bit_en),
      .start_i (start_q),
      .fsync_o (fsync),
      .run_o   (run_q),
      .slot_o  (slot_q),
      .bit_o   (bit_q)
   );

   tdm_fr_bitsel #(.NCH(NCH), .W(W), .MSB_FIRST(MSB_FIRST)) u_sel (
      .words_i (words_q),
      .mask_i  (mask_q),
      .mode_i  (mode_q),
      .run_i   (run_q),
      .slot_i  (slot_q),
      .bit_i   (bit_q),
      .sd_o    (sd_out),
      .oe_o    (sd_oe)
   );

endmodule

// File: rtl/tdm_framer_chk.sv
module tdm_framer_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       bit_en,
   input logic       smp_stb,
   input logic       fsync,
   input logic       sd_oe,
   input logic       sd_out,
   input logic       overrun,
   input logic [1:0] mode_q
);

   AST_SYNC_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fsync) |-> $past(bit_en)) else $error("fsync rose without a tick"); // R1

   AST_SYNC_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      fsync |-> !sd_oe) else $error("data enabled during sync"); // R1

   AST_PROGRAM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'b00 || mode_q == 2'b11) |-> !sd_oe) else $error("enable in program mode"); // R4

   AST_QUIET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !sd_oe |-> !sd_out) else $error("data high while disabled"); // R10

   AST_OVR_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |-> $past(smp_stb)) else $error("overrun without strobe"); // R7

   AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(bit_en) && !$past(smp_stb)) |-> ($stable(sd_out) && $stable(sd_oe) && $stable(fsync)))
      else $error("output moved without tick"); // R11

endmodule

bind tdm_framer tdm_framer_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .bit_en  (bit_en),
   .smp_stb (smp_stb),
   .fsync   (fsync),
   .sd_oe   (sd_oe),
   .sd_out  (sd_out),
   .overrun (overrun),
   .mode_q  (mode_q)
);

// File: tb/tdm_framer_test.sv
module tdm_framer_test;

   localparam int CLK_PERIOD = 10;
   localparam int NCH = 6;
   localparam int W   = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             bit_en = 1'b0;
   logic             smp_stb = 1'b0;
   logic [NCH*W-1:0] smp_data = '0;
   logic [NCH-1:0]   pwr_mask = '0;
   logic [1:0]       mode = 2'b00;
   logic             sd_out, sd_oe, fsync, overrun;

   int checks = 0;
   int errors = 0;

   localparam logic [NCH*W-1:0] PAT_A = {16'hA5C3, 16'h0F0F, 16'h8001, 16'h7FFE, 16'hFFFF, 16'h1234};
   localparam logic [NCH*W-1:0] PAT_B = {16'h5A5A, 16'hC001, 16'h00FF, 16'hE38E, 16'h0001, 16'h9BDF};

   always #(CLK_PERIOD/2) clk = ~clk;

   tdm_framer #(.NCH(NCH), .W(W)) uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_en   (bit_en),
      .smp_stb  (smp_stb),
      .smp_data (smp_data),
      .pwr_mask (pwr_mask),
      .mode     (mode),
      .sd_out   (sd_out),
      .sd_oe    (sd_oe),
      .fsync    (fsync),
      .overrun  (overrun)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk) bit_en = 1'b1;
      @(negedge clk) bit_en = 1'b0;
   endtask

   task automatic strobe(input logic [NCH*W-1:0] d, input logic [NCH-1:0] m,
                         input logic [1:0] md, input bit exp_ovr);
      @(negedge clk);
      smp_data = d; pwr_mask = m; mode = md; smp_stb = 1'b1;
      @(negedge clk) smp_stb = 1'b0;
      check(overrun == exp_ovr, "R7", "overrun after strobe", overrun, exp_ovr);
      @(negedge clk);
      check(overrun == 1'b0, "R7", "overrun pulse length", overrun, 0);
   endtask

   // walks one full frame that was already started by a strobe
   task automatic check_frame(input logic [NCH*W-1:0] d, input logic [NCH-1:0] m,
                              input logic [1:0] md, input string tag);
      bit sends = (md == 2'b01) || (md == 2'b10);
      tick();
      check(fsync == 1'b1, "R1", "fsync on first tick", fsync, 1);
      check(sd_oe == 1'b0, "R1", "oe during sync", sd_oe, 0);
      for (int b = 0; b < NCH*W; b++) begin
         int slot = b / W;
         int bi   = W - 1 - (b % W);
         logic eoe, eout;
         eoe  = sends && m[slot];
         eout = eoe && d[slot*W + bi];
         tick();
         check(fsync == 1'b0, tag, "fsync inside frame", fsync, 0);
         check(sd_oe == eoe, tag, $sformatf("oe slot %0d bit %0d", slot, bi), sd_oe, eoe);
         check(sd_out == eout, tag, $sformatf("data slot %0d bit %0d", slot, bi), sd_out, eout);
         if (!eoe) check(sd_out == 1'b0, "R10", "data low when disabled", sd_out, 0);
         @(negedge clk);
         check(sd_out == eout && sd_oe == eoe, "R11", "hold between ticks",
               {sd_oe, sd_out}, {eoe, eout});
      end
      tick();
      check(sd_oe == 1'b0 && fsync == 1'b0, "R8", "quiet after last slot", {fsync, sd_oe}, 0);
      tick();
      check(sd_oe == 1'b0 && fsync == 1'b0, "R8", "no sync without strobe", {fsync, sd_oe}, 0);
   endtask

   task automatic t_reset();
      check({fsync, sd_oe, sd_out, overrun} == 4'b0, "R9", "outputs at reset",
            {fsync, sd_oe, sd_out, overrun}, 0);
      for (int i = 0; i < 4; i++) begin
         tick();
         check({fsync, sd_oe, sd_out, overrun} == 4'b0, "R9", "idle ticks after reset",
               {fsync, sd_oe, sd_out, overrun}, 0);
      end
   endtask

   task automatic t_all_data();
      strobe(PAT_A, 6'h3F, 2'b01, 1'b0);
      check_frame(PAT_A, 6'h3F, 2'b01, "R2");
   endtask

   task automatic t_subset();
      strobe(PAT_B, 6'b010101, 2'b10, 1'b0);
      check_frame(PAT_B, 6'b010101, 2'b10, "R3");
      strobe(PAT_A, 6'b100010, 2'b01, 1'b0);
      check_frame(PAT_A, 6'b100010, 2'b01, "R3");
   endtask

   task automatic t_program();
      strobe(PAT_A, 6'h3F, 2'b00, 1'b0);
      check_frame(PAT_A, 6'h3F, 2'b00, "R4");
   endtask

   task automatic t_reserved();
      strobe(PAT_B, 6'h3F, 2'b11, 1'b0);
      check_frame(PAT_B, 6'h3F, 2'b11, "R5");
      strobe(PAT_B, 6'h3F, 2'b10, 1'b0);
      check_frame(PAT_B, 6'h3F, 2'b10, "R5");
   endtask

   task automatic t_hold();
      strobe(PAT_A, 6'b110011, 2'b01, 1'b0);
      @(negedge clk);
      smp_data = ~PAT_A; pwr_mask = 6'b001100; mode = 2'b00;
      check_frame(PAT_A, 6'b110011, 2'b01, "R6");
   endtask

   task automatic t_overrun();
      strobe(PAT_A, 6'h3F, 2'b01, 1'b0);
      tick();
      check(fsync == 1'b1, "R1", "sync before interruption", fsync, 1);
      for (int i = 0; i < 10; i++) tick();
      strobe(PAT_B, 6'h3F, 2'b01, 1'b1);
      check_frame(PAT_B, 6'h3F, 2'b01, "R7");
      // strobe while still pending (no tick in between)
      strobe(PAT_A, 6'h3F, 2'b01, 1'b0);
      strobe(PAT_B, 6'h2A, 2'b10, 1'b1);
      check_frame(PAT_B, 6'h2A, 2'b10, "R7");
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_all_data();
      t_subset();
      t_program();
      t_reserved();
      t_hold();
      t_overrun();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule